// File: doc/BRIEF.md
# Bulk-Release Receive Byte Buffer

This block holds received serial bytes until a host collects them in bulk. Bytes come in from a deserializer on a one-cycle valid strobe and are stored in arrival order. The host does not pop bytes one at a time. It reads the fill count from a packed status word, copies a run of bytes through a word-wide read window that always starts at the oldest unread byte, and then writes the number of bytes it consumed. That single write frees all of those bytes in one cycle.

Two requests tell the host when to collect data. The data-available request rises when the fill reaches a level chosen by a 3-bit code, from a ladder of powers of two. The character-timeout request rises when data has been waiting with no new byte and no release write for a programmed time. That time is measured in units of four baud-divisor periods, so it scales with the line rate. A byte that arrives while the store is full is discarded, and a sticky overrun flag records the loss.

Top module: `rxb_bulk_rx`

## Requirements
- R1: The store keeps up to DEPTH-1 (1023) bytes, accepted in arrival order on `rx_valid`. `fill_count` rises by one on the clock edge where a byte is accepted.
- R2: `status_word` packs the following fields:
  - bits 31:24 hold fill bits 7:0.
  - bits 7:6 hold fill bits 9:8.
  - bit 0 is the data-available request.
  - bit 1 is the character-timeout request.
  - bit 2 is the overrun flag.
  - all other bits read 0.
- R3: After a cycle with `win_rd` high, `win_rdata` holds window word `win_word` on the following cycle. Lane k (bits 8k+7:8k) of word w is the byte at position 4w+k counted from the oldest unread byte.
- R4: A write on `ack_wr` with count N, where N is not larger than the fill, releases exactly N bytes. Window position 0 then moves to what was position N.
- R5: A release count larger than the current fill is clamped to the fill, so the store becomes empty.
- R6: `irq_data_avail` is high exactly when the fill is at least 4·2^code, where code is `cfg_trig_code`. Code 0 means 4 bytes and code 6 means 256 bytes.
- R7: With timeout T>0 and divisor D>0, `irq_char_timeout` rises T·4·D cycles after the last restart edge if data is present. It is separate from `irq_data_avail`.
- R8: These rules control the idle timer:
  - Every `rx_valid` strobe restarts it and clears the timeout request.
  - Every `ack_wr` write restarts it and clears the timeout request, including a write with count 0.
  - The timer is held at zero while the store is empty.
  - A timeout value of 0 disables the timer.
- R9: A byte that arrives while the store is full is dropped. The fill and the stored data stay unchanged, and `overrun` is set. The overrun flag stays set until the next `ack_wr`.
- R10: The window spans 1020 bytes (words 0 to 254). A read of word 255 returns all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Strobe: one received byte is on `rx_byte` |
| rx_byte | input | 8 | Received byte |
| win_rd | input | 1 | Read one word of the window |
| win_word | input | 8 | Word index into the window |
| win_rdata | output | 32 | Window read data, oldest byte in the low lane |
| ack_wr | input | 1 | Release write strobe |
| ack_count | input | 10 | Number of bytes to release |
| cfg_trig_code | input | 3 | Data-available trigger code |
| cfg_timeout | input | 16 | Idle timeout in tick units, 0 disables the timer |
| cfg_baud_div | input | 16 | Baud divisor; one tick is 4 divisor periods |
| fill_count | output | 10 | Bytes currently stored |
| irq_data_avail | output | 1 | Fill has reached the trigger level |
| irq_char_timeout | output | 1 | Data has been idle past the timeout |
| overrun | output | 1 | Sticky flag: a byte was dropped |
| status_word | output | 32 | Packed fill count and flags |

## Verification
Directed cases cover the main corner cases:
- Filling the store to its last slot and pushing one more byte separates a correct drop from a pointer wrap, which would corrupt the oldest byte.
- An oversized release separates clamping from an underflow of the fill.
- Counting the exact cycle on which the timeout request rises, after a byte and again after a zero-count release, separates the right tick length and restart sources from timers that are off by one or ignore one of the restart sources.

A seeded random mix of pushes, partial releases and window reads at random offsets tests the read-pointer arithmetic across wraparound against a byte-queue model in the bench. It also tests the trigger compare for several codes.

// File: rtl/rxb_pkg.sv
package rxb_pkg;

  // Packed status word seen by the host
  typedef struct packed {
    logic [7:0]  fill_lo;
    logic [15:0] zero_hi;
    logic [1:0]  fill_hi;
    logic [2:0]  zero_lo;
    logic        ovr;
    logic        cto;
    logic        avail;
  } status_t;

  function automatic status_t pack_status(input logic [9:0] fill,
                                          input logic avail,
                                          input logic cto,
                                          input logic ovr);
    status_t s;
    s.fill_lo = fill[7:0];
    s.zero_hi = '0;
    s.fill_hi = fill[9:8];
    s.zero_lo = '0;
    s.ovr     = ovr;
    s.cto     = cto;
    s.avail   = avail;
    return s;
  endfunction

endpackage

// File: rtl/rxb_store.sv
module rxb_store #(
  parameter int DEPTH     = 1024,
  parameter int WIN_WORDS = 255,
  localparam int AW = $clog2(DEPTH),
  localparam int WW = $clog2(DEPTH / 4)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_ptr,
  input  logic [7:0]    wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_base,
  input  logic [WW-1:0] rd_word,
  output logic [31:0]   rdata
);

  logic [7:0]  mem [DEPTH];
  logic [31:0] lanes;
  logic [31:0] rdata_d;
  logic [AW-1:0] word_off;

  assign word_off = AW'({rd_word, 2'b00});

  // byte array, no reset on storage
  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_ptr] <= wr_data;
    end
  end

  for (genvar k = 0; k < 4; k++) begin : g_lane
    logic [AW-1:0] addr;
    assign addr = rd_base + word_off + AW'(k);
    assign lanes[8*k +: 8] = mem[addr];
  end

  always_comb begin
    rdata_d = rdata;
    if (rd_en) begin
      rdata_d = (32'(rd_word) < WIN_WORDS) ? lanes : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= rdata_d;
  end

endmodule

// File: rtl/rxb_level.sv
module rxb_level #(
  parameter int DEPTH  = 1024,
  parameter int TRIG_W = 3,
  localparam int AW    = $clog2(DEPTH),
  localparam int CNT_W = AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic              ack_wr,
  input  logic [CNT_W-1:0]  ack_count,
  input  logic [TRIG_W-1:0] trig_code,
  output logic              wr_en,
  output logic [AW-1:0]     wr_ptr,
  output logic [AW-1:0]     rd_ptr,
  output logic [CNT_W-1:0]  fill,
  output logic              ovr,
  output logic              avail
);

  localparam logic [CNT_W-1:0] MAX_FILL = CNT_W'(DEPTH - 1);

  logic [AW-1:0]    wr_ptr_d, rd_ptr_d;
  logic [CNT_W-1:0] fill_d, rel;
  logic             ovr_d, full, accept;
  logic [CNT_W:0]   thr;

  assign full   = (fill == MAX_FILL);
  assign accept = rx_valid && !full;
  assign wr_en  = accept;

  // trigger ladder: 4 << code
  assign thr   = (CNT_W + 1)'(4) << trig_code;
  assign avail = ({1'b0, fill} >= thr);

  always_comb begin
    rel = '0;
    if (ack_wr) begin
      rel = (ack_count > fill) ? fill : ack_count;
    end
    fill_d   = fill - rel + {{(CNT_W-1){1'b0}}, accept};
    wr_ptr_d = wr_ptr + {{(AW-1){1'b0}}, accept};
    rd_ptr_d = rd_ptr + rel;
    ovr_d    = ovr;
    if (ack_wr)             ovr_d = 1'b0;
    if (rx_valid && full)   ovr_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
      ovr    <= 1'b0;
    end else begin
      wr_ptr <= wr_ptr_d;
      rd_ptr <= rd_ptr_d;
      fill   <= fill_d;
      ovr    <= ovr_d;
    end
  end

endmodule

// File: rtl/rxb_idle_timer.sv
module rxb_idle_timer #(
  parameter int TO_W  = 16,
  parameter int DIV_W = 16,
  localparam int PW   = DIV_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             hold,
  input  logic [TO_W-1:0]  cfg_timeout,
  input  logic [DIV_W-1:0] cfg_div,
  output logic             expired
);

  logic [PW-1:0]   pre, pre_d, period;
  logic [TO_W-1:0] ticks, ticks_d, ticks_inc;
  logic            expired_d, run;

  // one tick spans four divisor periods; divisor 0 acts as 1
  assign period    = (cfg_div == '0) ? PW'(4) : {cfg_div, 2'b00};
  assign ticks_inc = ticks + TO_W'(1);
  assign run       = !expired && (cfg_timeout != '0);

  always_comb begin
    pre_d     = pre;
    ticks_d   = ticks;
    expired_d = expired;
    if (restart || hold) begin
      pre_d     = '0;
      ticks_d   = '0;
      expired_d = 1'b0;
    end else if (run) begin
      if (pre == period - PW'(1)) begin
        pre_d   = '0;
        ticks_d = ticks_inc;
        if (ticks_inc == cfg_timeout) expired_d = 1'b1;
      end else begin
        pre_d = pre + PW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre     <= '0;
      ticks   <= '0;
      expired <= 1'b0;
    end else begin
      pre     <= pre_d;
      ticks   <= ticks_d;
      expired <= expired_d;
    end
  end

endmodule

// File: rtl/rxb_bulk_rx.sv
module rxb_bulk_rx #(
  parameter int DEPTH     = 1024,
  parameter int WIN_BYTES = 1020,
  parameter int TRIG_W    = 3,
  parameter int TO_W      = 16,
  parameter int DIV_W     = 16,
  localparam int AW        = $clog2(DEPTH),
  localparam int CNT_W     = AW,
  localparam int WW        = $clog2(DEPTH / 4),
  localparam int WIN_WORDS = WIN_BYTES / 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  input  logic              win_rd,
  input  logic [WW-1:0]     win_word,
  output logic [31:0]       win_rdata,
  input  logic              ack_wr,
  input  logic [CNT_W-1:0]  ack_count,
  input  logic [TRIG_W-1:0] cfg_trig_code,
  input  logic [TO_W-1:0]   cfg_timeout,
  input  logic [DIV_W-1:0]  cfg_baud_div,
  output logic [CNT_W-1:0]  fill_count,
  output logic              irq_data_avail,
  output logic              irq_char_timeout,
  output logic              overrun,
  output logic [31:0]       status_word
);

  import rxb_pkg::*;

  logic          rst_s1, rst_sync_n;
  logic          wr_en;
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          expired;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s1     <= 1'b1;
      rst_sync_n <= rst_s1;
    end
  end

  rxb_level #(.DEPTH(DEPTH), .TRIG_W(TRIG_W)) u_level (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .rx_valid  (rx_valid),
    .ack_wr    (ack_wr),
    .ack_count (ack_count),
    .trig_code (cfg_trig_code),
    .wr_en     (wr_en),
    .wr_ptr    (wr_ptr),
    .rd_ptr    (rd_ptr),
    .fill      (fill_count),
    .ovr       (overrun),
    .avail     (irq_data_avail)
  );

  rxb_store #(.DEPTH(DEPTH), .WIN_WORDS(WIN_WORDS)) u_store (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (wr_en),
    .wr_ptr  (wr_ptr),
    .wr_data (rx_byte),
    .rd_en   (win_rd),
    .rd_base (rd_ptr),
    .rd_word (win_word),
    .rdata   (win_rdata)
  );

  rxb_idle_timer #(.TO_W(TO_W), .DIV_W(DIV_W)) u_timer (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .restart     (rx_valid || ack_wr),
    .hold        (fill_count == '0),
    .cfg_timeout (cfg_timeout),
    .cfg_div     (cfg_baud_div),
    .expired     (expired)
  );

  assign irq_char_timeout = expired;
  assign status_word = pack_status(10'(fill_count), irq_data_avail,
                                   irq_char_timeout, overrun);

endmodule

// File: rtl/rxb_bulk_rx_chk.sv
module rxb_bulk_rx_chk #(
  parameter int DEPTH     = 1024,
  parameter int WIN_BYTES = 1020,
  parameter int TRIG_W    = 3,
  localparam int CNT_W     = $clog2(DEPTH),
  localparam int WW        = $clog2(DEPTH / 4),
  localparam int WIN_WORDS = WIN_BYTES / 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_valid,
  input logic              win_rd,
  input logic [WW-1:0]     win_word,
  input logic [31:0]       win_rdata,
  input logic              ack_wr,
  input logic [CNT_W-1:0]  ack_count,
  input logic [TRIG_W-1:0] cfg_trig_code,
  input logic [CNT_W-1:0]  fill_count,
  input logic              irq_data_avail,
  input logic              irq_char_timeout,
  input logic              overrun,
  input logic [31:0]       status_word
);

  localparam logic [CNT_W-1:0] MAX_FILL = CNT_W'(DEPTH - 1);

  // R1
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !ack_wr && fill_count < MAX_FILL) |=>
      (fill_count == $past(fill_count) + CNT_W'(1)));

  // R5
  release_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_wr && !rx_valid) |=>
      (fill_count == ($past(ack_count) > $past(fill_count) ? '0 :
                      $past(fill_count) - $past(ack_count))));

  // R9
  drop_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !ack_wr && fill_count == MAX_FILL) |=>
      (overrun && fill_count == MAX_FILL));

  // R8
  empty_no_timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_count == '0) |-> !irq_char_timeout);

  // R6
  trigger_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_data_avail == ({1'b0, fill_count} >= ((CNT_W + 1)'(4) << cfg_trig_code)));

  // R2
  status_pack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_word[31:24] == fill_count[7:0]) && (status_word[2] == overrun) &&
    (status_word[1] == irq_char_timeout) && (status_word[0] == irq_data_avail));

  // R10
  window_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_rd && 32'(win_word) >= WIN_WORDS) |=> (win_rdata == '0));

endmodule

bind rxb_bulk_rx rxb_bulk_rx_chk #(
  .DEPTH(DEPTH), .WIN_BYTES(WIN_BYTES), .TRIG_W(TRIG_W)
) u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .rx_valid         (rx_valid),
  .win_rd           (win_rd),
  .win_word         (win_word),
  .win_rdata        (win_rdata),
  .ack_wr           (ack_wr),
  .ack_count        (ack_count),
  .cfg_trig_code    (cfg_trig_code),
  .fill_count       (fill_count),
  .irq_data_avail   (irq_data_avail),
  .irq_char_timeout (irq_char_timeout),
  .overrun          (overrun),
  .status_word      (status_word)
);

// File: tb/test_rxb_bulk_rx.sv
`timescale 1ns/1ps
module test_rxb_bulk_rx;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        rx_valid;
  logic [7:0]  rx_byte;
  logic        win_rd;
  logic [7:0]  win_word;
  logic [31:0] win_rdata;
  logic        ack_wr;
  logic [9:0]  ack_count;
  logic [2:0]  cfg_trig_code;
  logic [15:0] cfg_timeout;
  logic [15:0] cfg_baud_div;
  logic [9:0]  fill_count;
  logic        irq_data_avail;
  logic        irq_char_timeout;
  logic        overrun;
  logic [31:0] status_word;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  // bench byte-queue model
  logic [7:0] mq [1024];
  int mrd = 0, mwr = 0, mfill = 0;
  bit movr = 0;

  always #10 clk = ~clk;

  rxb_bulk_rx i_rxb_bulk_rx (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .win_rd(win_rd), .win_word(win_word), .win_rdata(win_rdata),
    .ack_wr(ack_wr), .ack_count(ack_count), .cfg_trig_code(cfg_trig_code),
    .cfg_timeout(cfg_timeout), .cfg_baud_div(cfg_baud_div),
    .fill_count(fill_count), .irq_data_avail(irq_data_avail),
    .irq_char_timeout(irq_char_timeout), .overrun(overrun),
    .status_word(status_word)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic exp_avail(input int f, input logic [2:0] code);
    return f >= (4 << code);
  endfunction

  function automatic logic [31:0] exp_status(input int f, input logic av,
                                             input logic cto, input logic ov);
    logic [9:0] f10;
    f10 = 10'(f);
    return {f10[7:0], 16'h0, f10[9:8], 3'b000, ov, cto, av};
  endfunction

  task automatic check_state(input logic cto);
    chk("R1 fill", 32'(fill_count), 32'(mfill));
    chk("R6 avail", 32'(irq_data_avail), 32'(exp_avail(mfill, cfg_trig_code)));
    chk("R9 overrun", 32'(overrun), 32'(movr));
    chk("R2 status", status_word,
        exp_status(mfill, exp_avail(mfill, cfg_trig_code), cto, movr));
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1;
    rx_byte  = b;
    @(negedge clk);
    rx_valid = 1'b0;
    if (mfill == 1023) movr = 1;
    else begin
      mq[mwr] = b;
      mwr = (mwr + 1) % 1024;
      mfill++;
    end
  endtask

  task automatic release_n(input int n);
    int rel;
    @(negedge clk);
    ack_wr    = 1'b1;
    ack_count = 10'(n);
    @(negedge clk);
    ack_wr = 1'b0;
    rel = (n > mfill) ? mfill : n;
    mrd = (mrd + rel) % 1024;
    mfill -= rel;
    movr = 0;
  endtask

  task automatic read_word(input int w, output logic [31:0] d);
    @(negedge clk);
    win_rd   = 1'b1;
    win_word = 8'(w);
    @(negedge clk);
    win_rd = 1'b0;
    d = win_rdata;
  endtask

  // compare lanes that lie inside the fill; word 255 must be zero
  task automatic check_word(input string req, input int w);
    logic [31:0] d, exp, mask;
    read_word(w, d);
    exp = '0;
    mask = '0;
    if (w < 255) begin
      for (int k = 0; k < 4; k++) begin
        if (4 * w + k < mfill) begin
          exp[8*k +: 8]  = mq[(mrd + 4 * w + k) % 1024];
          mask[8*k +: 8] = 8'hFF;
        end
      end
    end else begin
      mask = '1;
    end
    chk(req, d & mask, exp);
  endtask

  initial begin
    int to_wait;
    to_wait = 0;
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1357_2468));
    rst_n = 1'b0;
    rx_valid = 0; rx_byte = 0; win_rd = 0; win_word = 0;
    ack_wr = 0; ack_count = 0;
    cfg_trig_code = 3'd0; cfg_timeout = 16'd0; cfg_baud_div = 16'd1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state
    check_state(1'b0);
    chk("R7 cto reset", 32'(irq_char_timeout), 0);

    // R6 trigger code 0 = 4 bytes
    push(8'h11); push(8'h22); push(8'h33);
    chk("R6 below level", 32'(irq_data_avail), 0);
    push(8'h44);
    chk("R6 at level", 32'(irq_data_avail), 1);
    check_state(1'b0);

    // R3 window word 0 lanes in arrival order
    check_word("R3 word0", 0);
    // R4 release two, window shifts
    release_n(2);
    check_state(1'b0);
    check_word("R4 shifted word0", 0);
    // R5 oversized release clamps
    release_n(50);
    chk("R5 clamp fill", 32'(fill_count), 0);
    check_state(1'b0);

    // R7 / R8 idle timeout: divisor 2, timeout 3 -> 24 cycles
    @(negedge clk);
    cfg_baud_div = 16'd2;
    cfg_timeout  = 16'd3;
    repeat (100) @(negedge clk);
    chk("R8 held while empty", 32'(irq_char_timeout), 0);
    push(8'hA5);
    repeat (23) @(negedge clk);
    chk("R7 before expiry", 32'(irq_char_timeout), 0);
    @(negedge clk);
    chk("R7 at expiry", 32'(irq_char_timeout), 1);
    chk("R7 separate from avail", 32'(irq_data_avail), 0);
    chk("R2 status cto", status_word, exp_status(1, 1'b0, 1'b1, 1'b0));
    release_n(0);
    chk("R8 release restarts", 32'(irq_char_timeout), 0);
    repeat (23) @(negedge clk);
    chk("R8 before expiry", 32'(irq_char_timeout), 0);
    @(negedge clk);
    chk("R8 expiry after release", 32'(irq_char_timeout), 1);
    release_n(1);
    chk("R8 empty clears", 32'(irq_char_timeout), 0);
    @(negedge clk);
    cfg_timeout = 16'd0;

    // R1 / R2 fill to capacity
    for (int i = 0; i < 1023; i++) push(8'((i * 7 + 3) & 8'hFF));
    check_state(1'b0);
    chk("R2 fill lo", 32'(status_word[31:24]), 32'hFF);
    chk("R2 fill hi", 32'(status_word[7:6]), 32'h3);
    @(negedge clk);
    cfg_trig_code = 3'd7;
    @(negedge clk);
    chk("R6 code7", 32'(irq_data_avail), 1);
    // R9 drop when full
    push(8'hEE);
    chk("R9 overrun set", 32'(overrun), 1);
    check_state(1'b0);
    check_word("R9 oldest intact", 0);
    // R10 window limit
    check_word("R10 last word", 254);
    check_word("R10 past window", 255);
    release_n(516);
    chk("R9 overrun cleared", 32'(overrun), 0);
    chk("R2 fill 507 status", status_word, exp_status(507, 1'b0, 1'b0, 1'b0));
    check_word("R4 after bulk release", 3);

    // seeded random mix
    for (int it = 0; it < 500; it++) begin
      int op;
      op = int'($urandom % 6);
      if (it % 60 == 0) begin
        @(negedge clk);
        cfg_trig_code = 3'($urandom % 8);
      end
      if (op < 3) push(8'($urandom));
      else if (op == 3) release_n(int'($urandom % (mfill + 9)) % 1024);
      else check_word("R3 random word", int'($urandom % 256));
      check_state(1'b0);
      chk("R8 disabled timer", 32'(irq_char_timeout), 0);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule